// File: doc/BRIEF.md
# Multiplexed BCD Digit Scanner

This block presents a five-digit decimal reading one digit at a time. When an end-of-conversion pulse arrives it captures the five BCD digits and the overrange flag of the new result. It then cycles a one-hot digit select from the most significant digit down to the least significant and puts the matching 4-bit code on a shared data bus. A display can use the selects for multiplexing. A UART bridge, processor or external latch can instead grab each digit on an active-low strobe, which is centred in each digit slot.

Time is counted in counts. One count is two cycles of the system clock, so a half-count strobe lasts exactly one system cycle. The first slot, for the most significant digit, is one count longer than the other four. Strobes are issued on the first scan pass after a new result and on no later pass.

When the captured result is overrange, the data bus reads zero. After the last strobe the selects go dark and stay dark until a reference-integrate start pulse arrives, so the display blinks once per conversion. Reset is synchronous and active high.

Top module: `bcd_digit_scanner`

## Requirements
- R1: At most one bit of `dsel_o` is high at any time. `dsel_o[4]` selects the most significant digit and `dsel_o[0]` the least significant. Scanning runs 4,3,2,1,0 and then repeats. The first select rises in the system cycle after the edge that samples `eoc_i`.
- R2: The select for the most significant digit stays high for 402 system cycles (201 counts). Each of the other four selects stays high for 400 system cycles (200 counts), and each slot follows the previous one with no gap.
- R3: On the first pass after `eoc_i`, `strobe_n_o` goes low 202 system cycles after the most significant select rises. In every other slot it goes low 200 system cycles after that slot's select rises.
- R4: Each strobe pulse lasts exactly one system cycle.
- R5: A captured result produces exactly five strobes, and later scan passes produce none until the next `eoc_i`.
- R6: `bcd_o` carries the digit of the active select in the same cycle as the select. Digit k is taken from `digits_i[4k+3:4k]`, so bits [19:16] hold the most significant digit. `bcd_o` is 0 whenever no select is high.
- R7: When the captured overrange flag is 1, `bcd_o` is 0 in every cycle.
- R8: When the captured overrange flag is 1, all selects go low from the cycle after the fifth strobe. They stay low until `ref_go_i` is sampled high. Scanning then restarts at the most significant slot in the next cycle, without strobes. `ref_go_i` has no effect while scanning is running.
- R9: The digits and the overrange flag are sampled only on `eoc_i`. A change on `digits_i` between pulses does not reach `bcd_o`. A new `eoc_i` in the middle of a scan restarts the scan at once, with fresh strobes.
- R10: After reset and until the first `eoc_i`, `dsel_o` is 0, `bcd_o` is 0 and `strobe_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, two cycles per count |
| rst | input | 1 | Synchronous active-high reset |
| eoc_i | input | 1 | End-of-conversion pulse; captures the result |
| ovr_i | input | 1 | Overrange flag of the result, sampled with `eoc_i` |
| digits_i | input | 20 | Five BCD digits, most significant in [19:16] |
| ref_go_i | input | 1 | Reference-integrate start pulse; ends overrange blanking |
| dsel_o | output | 5 | One-hot digit select, bit 4 = most significant |
| bcd_o | output | 4 | BCD code of the selected digit, positive true |
| strobe_n_o | output | 1 | Active-low data strobe, one system cycle wide |

## Verification
A slot counter that is off by one first shows up as a select edge one cycle early or late. For the long first slot, that edge appears within the first 403 cycles after the capture pulse. A missed strobe-enable clear does not show until the second pass, about 2000 cycles in, when unexpected low pulses appear. The bench therefore observes at least two full passes of every result. A wrong blanking state shows either as selects that stay live after the fifth strobe, or as a scan that fails to restart one cycle after the reference pulse. The bench compares every cycle of each trace with a model built from the requirements.

// File: rtl/dscan_pkg.sv
package dscan_pkg;
  typedef enum logic [1:0] {
    SC_IDLE  = 2'd0,
    SC_RUN   = 2'd1,
    SC_BLANK = 2'd2
  } scan_mode_e;
endpackage

// File: rtl/dscan_timer.sv
module dscan_timer
  import dscan_pkg::*;
#(
  parameter int NDIG     = 5,
  parameter int SLOT_HC  = 400,
  parameter int FIRST_HC = 402,
  localparam int SW = $clog2(NDIG),
  localparam int HW = $clog2(FIRST_HC)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          eoc,
  input  logic          ref_go,
  input  logic          blank_req,
  output scan_mode_e    mode,
  output logic [SW-1:0] slot,
  output logic [HW-1:0] hc
);
  localparam logic [SW-1:0] LAST_SLOT  = SW'(NDIG - 1);
  localparam logic [HW-1:0] FIRST_LAST = HW'(FIRST_HC - 1);
  localparam logic [HW-1:0] OTHER_LAST = HW'(SLOT_HC - 1);

  logic [HW-1:0] end_hc;
  assign end_hc = (slot == '0) ? FIRST_LAST : OTHER_LAST;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= SC_IDLE;
      slot <= '0;
      hc   <= '0;
    end else if (eoc) begin
      mode <= SC_RUN;
      slot <= '0;
      hc   <= '0;
    end else begin
      case (mode)
        SC_RUN: begin
          if (blank_req) begin
            mode <= SC_BLANK;
          end else if (hc == end_hc) begin
            hc   <= '0;
            slot <= (slot == LAST_SLOT) ? '0 : slot + 1'b1;
          end else begin
            hc <= hc + 1'b1;
          end
        end
        SC_BLANK: begin
          if (ref_go) begin
            mode <= SC_RUN;
            slot <= '0;
            hc   <= '0;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dscan_strobe.sv
module dscan_strobe #(
  parameter int NDIG         = 5,
  parameter int FIRST_HC     = 402,
  parameter int FIRST_STB_HC = 202,
  parameter int OTHER_STB_HC = 200,
  localparam int SW = $clog2(NDIG),
  localparam int HW = $clog2(FIRST_HC)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          eoc,
  input  logic          run,
  input  logic [SW-1:0] slot,
  input  logic [HW-1:0] hc,
  output logic          stb_now,
  output logic          final_now
);
  localparam logic [SW-1:0] LAST_SLOT = SW'(NDIG - 1);
  localparam logic [HW-1:0] FIRST_AT  = HW'(FIRST_STB_HC);
  localparam logic [HW-1:0] OTHER_AT  = HW'(OTHER_STB_HC);

  logic armed;

  assign stb_now   = armed && run && (hc == ((slot == '0) ? FIRST_AT : OTHER_AT));
  assign final_now = stb_now && (slot == LAST_SLOT);

  always_ff @(posedge clk) begin
    if (rst)            armed <= 1'b0;
    else if (eoc)       armed <= 1'b1;
    else if (final_now) armed <= 1'b0;
  end
endmodule

// File: rtl/dscan_capture.sv
module dscan_capture #(
  parameter int NDIG  = 5,
  parameter int BCD_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  eoc,
  input  logic                  ovr,
  input  logic [NDIG*BCD_W-1:0] digits,
  output logic [BCD_W-1:0]      dig_q [NDIG],
  output logic                  ovr_q
);
  always_ff @(posedge clk) begin
    if (rst)      ovr_q <= 1'b0;
    else if (eoc) ovr_q <= ovr;
  end

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    always_ff @(posedge clk) begin
      if (rst)      dig_q[g] <= '0;
      else if (eoc) dig_q[g] <= digits[g*BCD_W +: BCD_W];
    end
  end
endmodule

// File: rtl/bcd_digit_scanner.sv
module bcd_digit_scanner
  import dscan_pkg::*;
#(
  parameter int NDIG            = 5,
  parameter int BCD_W           = 4,
  parameter int SLOT_CNT        = 200,
  parameter int FIRST_EXTRA     = 1,
  parameter int STB_OFS         = 100,
  parameter int FIRST_STB_EXTRA = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  eoc_i,
  input  logic                  ovr_i,
  input  logic [NDIG*BCD_W-1:0] digits_i,
  input  logic                  ref_go_i,
  output logic [NDIG-1:0]       dsel_o,
  output logic [BCD_W-1:0]      bcd_o,
  output logic                  strobe_n_o
);
  localparam int SLOT_HC      = 2 * SLOT_CNT;
  localparam int FIRST_HC     = 2 * (SLOT_CNT + FIRST_EXTRA);
  localparam int OTHER_STB_HC = 2 * STB_OFS;
  localparam int FIRST_STB_HC = 2 * (STB_OFS + FIRST_STB_EXTRA);
  localparam int SW           = $clog2(NDIG);
  localparam int HW           = $clog2(FIRST_HC);

  scan_mode_e      mode;
  logic [SW-1:0]   slot;
  logic [HW-1:0]   hc;
  logic            stb_now, final_now;
  logic [BCD_W-1:0] dig_q [NDIG];
  logic            ovr_q;
  logic            running;
  logic [NDIG-1:0] sel_dec;
  logic [SW-1:0]   dig_idx;

  assign running = (mode == SC_RUN);

  dscan_timer #(.NDIG(NDIG), .SLOT_HC(SLOT_HC), .FIRST_HC(FIRST_HC)) timer_i (
    .clk(clk), .rst(rst), .eoc(eoc_i), .ref_go(ref_go_i),
    .blank_req(final_now && ovr_q), .mode(mode), .slot(slot), .hc(hc)
  );

  dscan_strobe #(.NDIG(NDIG), .FIRST_HC(FIRST_HC), .FIRST_STB_HC(FIRST_STB_HC),
                 .OTHER_STB_HC(OTHER_STB_HC)) strobe_i (
    .clk(clk), .rst(rst), .eoc(eoc_i), .run(running), .slot(slot), .hc(hc),
    .stb_now(stb_now), .final_now(final_now)
  );

  dscan_capture #(.NDIG(NDIG), .BCD_W(BCD_W)) capture_i (
    .clk(clk), .rst(rst), .eoc(eoc_i), .ovr(ovr_i), .digits(digits_i),
    .dig_q(dig_q), .ovr_q(ovr_q)
  );

  // slot 0 is the most significant digit, which sits at the top index
  assign dig_idx = SW'(NDIG - 1) - slot;

  for (genvar g = 0; g < NDIG; g++) begin : g_sel
    assign sel_dec[g] = (dig_idx == SW'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dsel_o     <= '0;
      bcd_o      <= '0;
      strobe_n_o <= 1'b1;
    end else begin
      dsel_o     <= running ? sel_dec : '0;
      bcd_o      <= (running && !ovr_q) ? dig_q[dig_idx] : '0;
      strobe_n_o <= !stb_now;
    end
  end
endmodule

// File: rtl/dscan_checker.sv
module dscan_checker #(
  parameter int NDIG  = 5,
  parameter int BCD_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             eoc_i,
  input logic             ovr_i,
  input logic [NDIG-1:0]  dsel_o,
  input logic [BCD_W-1:0] bcd_o,
  input logic             strobe_n_o
);
  logic ovr_seen;

  always_ff @(posedge clk) begin
    if (rst)        ovr_seen <= 1'b0;
    else if (eoc_i) ovr_seen <= ovr_i;
  end

  assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dsel_o));

  assert_stb_in_slot_R3: assert property (@(posedge clk) disable iff (rst)
    !strobe_n_o |-> (dsel_o != '0));

  assert_stb_width_R4: assert property (@(posedge clk) disable iff (rst)
    !strobe_n_o |=> strobe_n_o);

  assert_bcd_needs_sel_R6: assert property (@(posedge clk) disable iff (rst)
    (bcd_o != '0) |-> (dsel_o != '0));

  assert_ovr_zero_R7: assert property (@(posedge clk) disable iff (rst)
    $past(ovr_seen) |-> (bcd_o == '0));
endmodule

bind bcd_digit_scanner dscan_checker #(.NDIG(NDIG), .BCD_W(BCD_W)) chk_i (
  .clk(clk), .rst(rst), .eoc_i(eoc_i), .ovr_i(ovr_i),
  .dsel_o(dsel_o), .bcd_o(bcd_o), .strobe_n_o(strobe_n_o)
);

// File: tb/bcd_digit_scanner_tb_top.sv
module bcd_digit_scanner_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PASS_LEN   = 2002;
  localparam int FIRST_LEN  = 402;
  localparam int SLOT_LEN   = 400;
  localparam int NVEC       = 6;
  // bit 20 = overrange, bits 19:0 = digits
  localparam logic [20:0] VEC [NVEC] = '{
    {1'b0, 20'h12345}, {1'b0, 20'h09876}, {1'b1, 20'h19999},
    {1'b0, 20'h10000}, {1'b0, 20'h00000}, {1'b1, 20'h00001}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic eoc = 1'b0, ovr = 1'b0, ref_go = 1'b0;
  logic [19:0] digits = '0;
  logic [4:0] dsel;
  logic [3:0] bcd;
  logic strobe_n;
  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_digit_scanner dut_i (
    .clk(clk), .rst(rst), .eoc_i(eoc), .ovr_i(ovr), .digits_i(digits),
    .ref_go_i(ref_go), .dsel_o(dsel), .bcd_o(bcd), .strobe_n_o(strobe_n)
  );

  task automatic model(input int k, input logic [19:0] dg, input bit ov, input int refk,
                       output logic [4:0] ed, output logic [3:0] eb, output logic es);
    int idx, pass, pos, slot, off, tgt;
    bit fresh, noblank, blank;
    fresh = 1; noblank = 0; idx = k - 1;
    if (ov && refk > 0 && k >= refk + 2) begin
      idx = k - refk - 2; fresh = 0; noblank = 1;
    end
    pass = idx / PASS_LEN;
    pos  = idx % PASS_LEN;
    if (pos < FIRST_LEN) begin slot = 0; off = pos; end
    else begin slot = 1 + (pos - FIRST_LEN) / SLOT_LEN; off = (pos - FIRST_LEN) % SLOT_LEN; end
    tgt   = (slot == 0) ? 202 : 200;
    blank = ov && !noblank && (pass > 0 || (slot == 4 && off > 200));
    ed = blank ? 5'd0 : 5'(1 << (4 - slot));
    eb = (blank || ov) ? 4'd0 : dg[4*(4-slot) +: 4];
    es = !(fresh && pass == 0 && off == tgt && !blank);
  endtask

  task automatic check(input bit ok, input string what);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s", what);
    end
  endtask

  task automatic run_scan(input logic [19:0] dg, input bit ov, input int ncyc,
                          input int refk, input bit scramble);
    logic [4:0] ed; logic [3:0] eb; logic es;
    bit bad_d = 0, bad_b = 0, bad_s = 0;
    int obs_stb = 0, exp_stb = 0;
    @(posedge clk); #1;
    eoc = 1'b1; digits = dg; ovr = ov;
    @(posedge clk); #1;
    eoc = 1'b0; ovr = 1'b0;
    for (int k = 1; k <= ncyc; k++) begin
      @(posedge clk); #1;
      model(k, dg, ov, refk, ed, eb, es);
      if (!strobe_n) obs_stb++;
      if (!es) exp_stb++;
      if (dsel !== ed && !bad_d) begin
        bad_d = 1;
        $display("FAIL R2 select at cycle %0d digits %h: got %b expected %b", k, dg, dsel, ed);
      end
      if (bcd !== eb && !bad_b) begin
        bad_b = 1;
        $display("FAIL R6 data at cycle %0d digits %h: got %h expected %h", k, dg, bcd, eb);
      end
      if (strobe_n !== es && !bad_s) begin
        bad_s = 1;
        $display("FAIL R3 strobe at cycle %0d digits %h: got %b expected %b", k, dg, strobe_n, es);
      end
      ref_go = (k == refk);
      if (scramble && k == 30) digits = ~dg;
    end
    ref_go = 1'b0;
    // mismatches are already printed above; these count them
    n_checks += 3;
    n_fail   += int'(bad_d) + int'(bad_b) + int'(bad_s);
    check(obs_stb == exp_stb,
          $sformatf("R5 strobe count for %h: got %0d expected %0d", dg, obs_stb, exp_stb));
  endtask

  initial begin
    bit rst_ok;
    rst_ok = 1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #1;
      if (dsel !== 5'd0 || bcd !== 4'd0 || strobe_n !== 1'b1) rst_ok = 0;
    end
    check(rst_ok, $sformatf("R10 idle after reset: got sel %b data %h stb %b expected 00000 0 1",
                            dsel, bcd, strobe_n));
    // table walk: two passes of each result (R1 R2 R3 R4 R5 R6 R7 R8)
    for (int v = 0; v < NVEC; v++)
      run_scan(VEC[v][19:0], VEC[v][20], 2 * PASS_LEN + 40, 0, 0);
    // R8: blanking ends on the reference pulse, scan restarts without strobes
    run_scan(20'h15555, 1'b1, 2500 + PASS_LEN + 10, 2500, 0);
    // R8: reference pulse ignored while scanning
    run_scan(20'h02468, 1'b0, PASS_LEN + 500, 100, 0);
    // R9: input changes between captures do not reach the bus
    run_scan(20'h13579, 1'b0, PASS_LEN + 100, 0, 1);
    // R9: capture in mid-scan restarts with fresh strobes
    run_scan(20'h11111, 1'b0, 700, 0, 0);
    run_scan(20'h08642, 1'b0, PASS_LEN + 100, 0, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule